// File: doc/BRIEF.md
# Floating-Point Compare Unit with Condition Codes

This block compares two single-precision binary floating-point operands, a stack-top value and a source value, and reports their relation as a three-bit condition code: greater, less, equal or unordered. Each operand is classified as zero, infinity, quiet NaN or signaling NaN before the ordering decision. A NaN in either operand always yields the unordered code.

An invalid-operation flag is raised when a NaN is present that the selected policy treats as invalid. When the invalid-operation mask input is clear, an exception request is also asserted so that an outside handler can take over. The operands are presented with a one-cycle compare strobe. All results are registered. A valid pulse marks the cycle after the strobe, and the results hold until the next strobe.

Top module: `fpc_cmp`

## Requirements
- R1: `cc_o` is {C3, C2, C0} with C3 in bit 2 and C0 in bit 0. Stack-top greater than source gives 3'b000, less gives 3'b001, equal gives 3'b100, and unordered gives 3'b111. No other code appears.
- R2: Operands use bit 31 as sign (1 = negative), bits 30:23 as exponent biased by 127, and bits 22:0 as fraction. Positive and negative zero compare equal in any pairing.
- R3: For ordered operands of opposite sign that are not both zero, the non-negative operand is the greater one. This holds for infinities as well.
- R4: For ordered operands of the same sign, the larger unsigned value of bits 30:0 is greater when both are positive and smaller when both are negative. Infinity (exponent all ones, fraction zero) lies beyond every finite value, and denormals order by magnitude.
- R5: If either operand has an all-ones exponent and a nonzero fraction, the code is 3'b111.
- R6: `qnan_o` is set when an operand is a NaN with fraction bit 22 set. `snan_o` is set when an operand is a NaN with fraction bit 22 clear. An infinity sets neither flag.
- R7: `inv_o` is set whenever a signaling NaN is present. With parameter SIG_ON_QNAN = 1 it is also set for any quiet NaN; with SIG_ON_QNAN = 0 it is not.
- R8: `exc_o` equals `inv_o` when the mask input sampled with the strobe is 0, and is 0 when that mask is 1. The code stays 3'b111 in both cases.
- R9: `valid_o` is a single-cycle pulse one clock after `start_i`. All other outputs change only in that same cycle and hold otherwise.
- R10: After reset, `cc_o` = 3'b000 and `valid_o`, `inv_o`, `exc_o`, `qnan_o` and `snan_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Compare strobe |
| st0_i | input | 32 | Stack-top operand |
| src_i | input | 32 | Source operand |
| inv_mask_i | input | 1 | Invalid-operation mask (1 = handled internally) |
| cc_o | output | 3 | Condition code {C3, C2, C0} |
| valid_o | output | 1 | Result-valid pulse |
| inv_o | output | 1 | Invalid-operation flag |
| exc_o | output | 1 | Exception request to outside handler |
| qnan_o | output | 1 | A quiet NaN operand was seen |
| snan_o | output | 1 | A signaling NaN operand was seen |

## Verification
The bench builds two copies of the block from the same stimulus. One uses SIG_ON_QNAN = 0 and the other uses SIG_ON_QNAN = 1, so both invalid policies are checked against quiet and signaling NaNs. Both copies use the default 8-bit exponent and 23-bit fraction, which puts the single-precision encodings of zeros, infinities, denormals and the largest finite value within reach. This also covers the fraction-MSB split between the two NaN kinds.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic qnan;
    logic snan;
  } fclass_t;

  localparam logic [2:0] CC_GT = 3'b000;
  localparam logic [2:0] CC_LT = 3'b001;
  localparam logic [2:0] CC_EQ = 3'b100;
  localparam logic [2:0] CC_UN = 3'b111;

  // Map an ordering relation onto the {C3,C2,C0} triple
  function automatic logic [2:0] cc_of(input rel_e rel);
    case (rel)
      REL_GT:  cc_of = CC_GT;
      REL_LT:  cc_of = CC_LT;
      REL_EQ:  cc_of = CC_EQ;
      default: cc_of = CC_UN;
    endcase
  endfunction

  function automatic logic is_nan(input fclass_t c);
    is_nan = c.qnan | c.snan;
  endfunction

endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
  import fpc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0]   opnd_i,
  output fclass_t                 cls_o,
  output logic [EXP_W+FRAC_W-1:0] mag_o
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = W - 1;
  localparam int QBIT   = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              sign_f;

  function automatic logic exp_full(input logic [EXP_W-1:0] e);
    exp_full = &e;
  endfunction

  function automatic logic exp_empty(input logic [EXP_W-1:0] e);
    exp_empty = ~|e;
  endfunction

  function automatic logic frac_any(input logic [FRAC_W-1:0] f);
    frac_any = |f;
  endfunction

  assign sign_f = opnd_i[W-1];
  assign exp_f  = opnd_i[MAG_W-1:FRAC_W];
  assign frac_f = opnd_i[FRAC_W-1:0];
  assign mag_o  = opnd_i[MAG_W-1:0];

  always_comb begin
    cls_o.sign = sign_f;
    cls_o.zero = exp_empty(exp_f) & ~frac_any(frac_f);
    cls_o.inf  = exp_full(exp_f)  & ~frac_any(frac_f);
    cls_o.qnan = exp_full(exp_f)  & frac_f[QBIT];
    cls_o.snan = exp_full(exp_f)  & ~frac_f[QBIT] & frac_any(frac_f);
  end

endmodule

// File: rtl/fpc_order.sv
module fpc_order
  import fpc_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  fclass_t          cls_a_i,
  input  fclass_t          cls_b_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic [MAG_W-1:0] mag_b_i,
  output rel_e             rel_o,
  output logic             mag_gt_o,
  output logic             mag_eq_o
);
  logic both_zero;
  logic unordered;
  logic sign_split;

  assign mag_gt_o   = mag_a_i > mag_b_i;
  assign mag_eq_o   = mag_a_i == mag_b_i;
  assign both_zero  = cls_a_i.zero & cls_b_i.zero;
  assign unordered  = is_nan(cls_a_i) | is_nan(cls_b_i);
  assign sign_split = cls_a_i.sign ^ cls_b_i.sign;

  always_comb begin
    if (unordered)        rel_o = REL_UN;
    else if (both_zero)   rel_o = REL_EQ;
    else if (sign_split)  rel_o = cls_a_i.sign ? REL_LT : REL_GT;
    else if (mag_eq_o)    rel_o = REL_EQ;
    else if (mag_gt_o ^ cls_a_i.sign) rel_o = REL_GT;
    else                  rel_o = REL_LT;
  end

endmodule

// File: rtl/fpc_cmp.sv
module fpc_cmp
  import fpc_pkg::*;
#(
  parameter int EXP_W       = 8,
  parameter int FRAC_W      = 23,
  parameter bit SIG_ON_QNAN = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [EXP_W+FRAC_W:0]   st0_i,
  input  logic [EXP_W+FRAC_W:0]   src_i,
  input  logic                    inv_mask_i,
  output logic [2:0]              cc_o,
  output logic                    valid_o,
  output logic                    inv_o,
  output logic                    exc_o,
  output logic                    qnan_o,
  output logic                    snan_o
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int MAG_W = W - 1;
  localparam int NOPS  = 2;

  logic [W-1:0]     opnd   [NOPS];
  fclass_t          cls    [NOPS];
  logic [MAG_W-1:0] mag    [NOPS];

  assign opnd[0] = st0_i;
  assign opnd[1] = src_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fpc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .opnd_i (opnd[g]),
      .cls_o  (cls[g]),
      .mag_o  (mag[g])
    );
  end

  rel_e rel;
  logic mag_gt;
  logic mag_eq;

  fpc_order #(.MAG_W(MAG_W)) u_ord (
    .cls_a_i  (cls[0]),
    .cls_b_i  (cls[1]),
    .mag_a_i  (mag[0]),
    .mag_b_i  (mag[1]),
    .rel_o    (rel),
    .mag_gt_o (mag_gt),
    .mag_eq_o (mag_eq)
  );

  // Named events for the checker and for waveform reading
  logic any_qnan;
  logic any_snan;
  logic inv_hit;
  logic exc_hit;

  assign any_qnan = cls[0].qnan | cls[1].qnan;
  assign any_snan = cls[0].snan | cls[1].snan;

  if (SIG_ON_QNAN) begin : g_pol_all
    assign inv_hit = any_snan | any_qnan;
  end else begin : g_pol_sig
    assign inv_hit = any_snan;
  end

  assign exc_hit = inv_hit & ~inv_mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_o    <= CC_GT;
      valid_o <= 1'b0;
      inv_o   <= 1'b0;
      exc_o   <= 1'b0;
      qnan_o  <= 1'b0;
      snan_o  <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        cc_o   <= cc_of(rel);
        inv_o  <= inv_hit;
        exc_o  <= exc_hit;
        qnan_o <= any_qnan;
        snan_o <= any_snan;
      end
    end
  end

endmodule

// File: rtl/fpc_cmp_chk.sv
module fpc_cmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       inv_mask_i,
  input logic [2:0] cc_o,
  input logic       valid_o,
  input logic       inv_o,
  input logic       exc_o,
  input logic       qnan_o,
  input logic       snan_o
);

  p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cc_o == 3'b000 || cc_o == 3'b001 || cc_o == 3'b100 || cc_o == 3'b111);

  p_nan_unordered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (qnan_o || snan_o) |-> cc_o == 3'b111);

  p_unordered_needs_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cc_o == 3'b111 |-> (qnan_o || snan_o));

  p_snan_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snan_o |-> inv_o);

  p_inv_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_o |-> cc_o == 3'b111);

  p_exc_needs_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> inv_o);

  p_exc_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(inv_mask_i)) |-> !exc_o);

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  p_valid_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(start_i));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(cc_o) && $stable(inv_o) && $stable(exc_o)
                  && $stable(qnan_o) && $stable(snan_o)));

endmodule

bind fpc_cmp fpc_cmp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .inv_mask_i (inv_mask_i),
  .cc_o       (cc_o),
  .valid_o    (valid_o),
  .inv_o      (inv_o),
  .exc_o      (exc_o),
  .qnan_o     (qnan_o),
  .snan_o     (snan_o)
);

// File: tb/test_fpc_cmp.sv
module test_fpc_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] st0_i = '0;
  logic [31:0] src_i = '0;
  logic        inv_mask_i = 1'b1;

  logic [2:0] cc_a, cc_b;
  logic valid_a, valid_b, inv_a, inv_b, exc_a, exc_b, qn_a, qn_b, sn_a, sn_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fpc_cmp #(.SIG_ON_QNAN(1'b0)) i_fpc_cmp (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .st0_i(st0_i), .src_i(src_i),
    .inv_mask_i(inv_mask_i), .cc_o(cc_a), .valid_o(valid_a), .inv_o(inv_a),
    .exc_o(exc_a), .qnan_o(qn_a), .snan_o(sn_a));

  fpc_cmp #(.SIG_ON_QNAN(1'b1)) i_fpc_cmp_all (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .st0_i(st0_i), .src_i(src_i),
    .inv_mask_i(inv_mask_i), .cc_o(cc_b), .valid_o(valid_b), .inv_o(inv_b),
    .exc_o(exc_b), .qnan_o(qn_b), .snan_o(sn_b));

  // ---------------- reference model ----------------
  function automatic bit r_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic bit r_qnan(input logic [31:0] x);
    return r_nan(x) && x[22];
  endfunction

  function automatic bit r_snan(input logic [31:0] x);
    return r_nan(x) && !x[22];
  endfunction

  // Monotonic unsigned key: both zeros collapse to one point
  function automatic logic [31:0] r_key(input logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    if (x[31]) return ~x;
    return x | 32'h8000_0000;
  endfunction

  function automatic logic [2:0] r_cc(input logic [31:0] a, input logic [31:0] b);
    if (r_nan(a) || r_nan(b)) return 3'b111;
    if (r_key(a) > r_key(b)) return 3'b000;
    if (r_key(a) < r_key(b)) return 3'b001;
    return 3'b100;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Strobe one compare and check both copies in the valid cycle
  task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic mask);
    bit q, s, i0, i1;
    @(negedge clk);
    st0_i = a; src_i = b; inv_mask_i = mask; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    q  = r_qnan(a) || r_qnan(b);
    s  = r_snan(a) || r_snan(b);
    i0 = s;
    i1 = s || q;
    chk("R9", "valid", {31'd0, valid_a}, 32'd1);
    chk(req,  "cc",    {29'd0, cc_a}, {29'd0, r_cc(a, b)});
    chk(req,  "cc_all",{29'd0, cc_b}, {29'd0, r_cc(a, b)});
    chk("R6", "qnan",  {31'd0, qn_a}, {31'd0, q});
    chk("R6", "snan",  {31'd0, sn_a}, {31'd0, s});
    chk("R7", "inv",   {31'd0, inv_a}, {31'd0, i0});
    chk("R7", "inv_all", {31'd0, inv_b}, {31'd0, i1});
    chk("R8", "exc",   {31'd0, exc_a}, {31'd0, i0 && !mask});
    chk("R8", "exc_all", {31'd0, exc_b}, {31'd0, i1 && !mask});
  endtask

  task automatic t_reset;
    chk("R10", "cc", {29'd0, cc_a}, 32'd0);
    chk("R10", "flags", {27'd0, valid_a, inv_a, exc_a, qn_a, sn_a}, 32'd0);
  endtask

  task automatic t_basic_r1;
    run("R1", 32'h4000_0000, 32'h3F80_0000, 1'b1);
    chk("R1", "gt code", {29'd0, cc_a}, 32'd0);
    run("R1", 32'h3F80_0000, 32'h4000_0000, 1'b1);
    chk("R1", "lt code", {29'd0, cc_a}, 32'd1);
    run("R1", 32'h3FC0_0000, 32'h3FC0_0000, 1'b1);
    chk("R1", "eq code", {29'd0, cc_a}, 32'd4);
  endtask

  task automatic t_zeros_r2;
    run("R2", 32'h0000_0000, 32'h8000_0000, 1'b1);
    run("R2", 32'h8000_0000, 32'h0000_0000, 1'b1);
    run("R2", 32'h8000_0000, 32'h8000_0000, 1'b1);
    chk("R2", "neg zeros eq", {29'd0, cc_a}, 32'd4);
  endtask

  task automatic t_signs_r3;
    run("R3", 32'h3F80_0000, 32'hBF80_0000, 1'b1);
    run("R3", 32'hFF80_0000, 32'h0000_0001, 1'b1);
    run("R3", 32'h7F80_0000, 32'hFF80_0000, 1'b1);
    run("R3", 32'h0000_0000, 32'hC000_0000, 1'b1);
  endtask

  task automatic t_magnitude_r4;
    run("R4", 32'hC000_0000, 32'hBF80_0000, 1'b1);
    run("R4", 32'hBF80_0000, 32'hC000_0000, 1'b1);
    run("R4", 32'h7F80_0000, 32'h7F7F_FFFF, 1'b1);
    run("R4", 32'hFF80_0000, 32'hFF7F_FFFF, 1'b1);
    run("R4", 32'h0000_0002, 32'h0000_0001, 1'b1);
    run("R4", 32'h0000_0001, 32'h0000_0000, 1'b1);
    run("R4", 32'h8000_0001, 32'h8000_0000, 1'b1);
  endtask

  task automatic t_nan_r5;
    run("R5", 32'h7FC0_0000, 32'h3F80_0000, 1'b1);
    run("R5", 32'h3F80_0000, 32'hFFC0_0001, 1'b1);
    run("R5", 32'h7F80_0001, 32'h7F80_0000, 1'b1);
    run("R5", 32'hFFA0_0000, 32'h7FC0_0000, 1'b1);
  endtask

  task automatic t_exc_r8;
    run("R8", 32'h7F80_0001, 32'h0000_0000, 1'b0);
    chk("R8", "exc unmasked snan", {31'd0, exc_a}, 32'd1);
    run("R8", 32'h7FC0_0000, 32'h0000_0000, 1'b0);
    chk("R8", "qnan exc policy", {30'd0, exc_a, exc_b}, 32'd1);
    run("R8", 32'h7F80_0001, 32'h0000_0000, 1'b1);
    chk("R8", "masked code", {29'd0, cc_a}, 32'd7);
    run("R8", 32'h3F80_0000, 32'h3F80_0000, 1'b0);
  endtask

  task automatic t_hold_r9;
    run("R9", 32'h7F80_0001, 32'h0000_0000, 1'b0);
    st0_i = 32'h3F80_0000; src_i = 32'h4000_0000; inv_mask_i = 1'b1;
    @(negedge clk);
    chk("R9", "valid drop", {31'd0, valid_a}, 32'd0);
    chk("R9", "cc held", {29'd0, cc_a}, 32'd7);
    chk("R9", "flags held", {29'd0, inv_a, exc_a, sn_a}, 32'd7);
    @(negedge clk);
    chk("R9", "still held", {29'd0, cc_a}, 32'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_r1();
    t_zeros_r2();
    t_signs_r3();
    t_magnitude_r4();
    t_nan_r5();
    t_exc_r8();
    t_hold_r9();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule